// File: doc/BRIEF.md
# Internal Data Memory Address Mapper

This block sits between the execution unit of an 8-bit microcontroller and the storage behind its internal data space. Each access gives an 8-bit address together with flags that say how to interpret it. The address can be a direct byte address, an indirect byte address, a register number, or a bit address. From these the block chooses one of three destinations: the lower 128 bytes of RAM, the upper 128 bytes of RAM, or a small register file of special-function registers. The register file holds the accumulator, a second arithmetic register, the status word and the two data-pointer bytes.

Byte reads and writes go straight to the chosen location. A bit operation names one bit. Its containing byte is read, changed and written back in the cycle of the request. The operation can clear, set, complement, or load the bit from the write data. Register references R0 to R7 are placed in the bank that the two bank-select bits of the status word choose. Reads return on a registered output one cycle after the request.

Top module: `idm_mapper`

## Requirements
- R1: After reset, rd_data is 00h, rd_valid and rd_bit are 0, acc_q is 00h, and the status word is 00h, so register references use bank 0.
- R2: Byte addresses 00h-7Fh reach the same lower RAM bytes whether indirect is 0 or 1.
- R3: With indirect=1, byte addresses 80h-FFh reach an upper RAM region that is separate from the special-function registers.
- R4: With indirect=0, byte addresses 80h-FFh reach the special-function registers. The accumulator is E0h and is also driven on acc_q. The second arithmetic register is F0h, the status word is D0h, the low data-pointer byte is 82h and the high data-pointer byte is 83h. Each of them reads back the value last written to it.
- R5: With indirect=0, an address in 80h-FFh that is none of the five registers reads as 00h, and a write to it changes nothing.
- R6: With reg_en=1, addr[2:0] selects register n, which sits at lower RAM byte bank*8+n, where bank is status-word bits 4:3.
- R7: With bit_en=1 and addr below 80h, the operation targets bit addr[2:0] of RAM byte 20h+addr[6:3].
- R8: With bit_en=1 and addr at or above 80h, the operation targets bit addr[2:0] of the special-function register at address {addr[7:3],000}.
- R9: With bit_en=1 and wr_en=1, bit_fn selects the change: 00 clears, 01 sets, 10 complements, and 11 loads wr_data[0]. The other seven bits of the byte keep their values. The new byte is in place for an access in the next cycle.
- R10: A request with rd_en=1 loads rd_data and raises rd_valid on the next clock edge. A cycle without rd_en drops rd_valid and leaves rd_data unchanged. Any bit operation loads rd_bit with the bit's value from before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write or bit-modify request |
| bit_en | input | 1 | addr is a bit address |
| reg_en | input | 1 | addr[2:0] is a register number |
| indirect | input | 1 | Byte access uses indirect addressing |
| bit_fn | input | 2 | Bit change: 00 clear, 01 set, 10 complement, 11 load |
| addr | input | 8 | Byte, bit or register address |
| wr_data | input | 8 | Write data; bit 0 is the load value for bit_fn 11 |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | rd_data was loaded by the previous request |
| rd_bit | output | 1 | Bit value before the last bit operation |
| acc_q | output | 8 | Current accumulator value |

## Verification
Every write and every bit change lands on the clock edge that samples the request. A read of the same location issued in the following cycle must therefore see the new value. rd_data, rd_valid and rd_bit change on that same edge. The bench drives each request on a falling edge and removes it on the next falling edge. It reads the outputs at that second falling edge, half a cycle after the edge that loaded them and before any later request can disturb them. acc_q is checked at the same point after a write, because it follows the accumulator register directly.

// File: rtl/idm_pkg.sv
package idm_pkg;
  typedef enum logic [1:0] {
    BF_CLR  = 2'b00,
    BF_SET  = 2'b01,
    BF_CPL  = 2'b10,
    BF_LOAD = 2'b11
  } bitfn_e;

  localparam logic [7:0] SFR_ACC = 8'hE0;
  localparam logic [7:0] SFR_B   = 8'hF0;
  localparam logic [7:0] SFR_PSW = 8'hD0;
  localparam logic [7:0] SFR_DPL = 8'h82;
  localparam logic [7:0] SFR_DPH = 8'h83;

  typedef struct packed {
    logic       sfr_sel;
    logic [7:0] idx;
    logic [2:0] bpos;
  } route_t;
endpackage

// File: rtl/idm_route.sv
module idm_route
  import idm_pkg::*;
#(
  parameter logic [7:0] BIT_BASE = 8'h20
) (
  input  logic [7:0] addr,
  input  logic       indirect,
  input  logic       reg_en,
  input  logic       bit_en,
  input  logic [1:0] bank,
  output route_t     route
);
  always_comb begin
    route.sfr_sel = 1'b0;
    route.idx     = addr;
    route.bpos    = addr[2:0];
    if (bit_en) begin
      if (!addr[7]) begin
        route.idx = BIT_BASE + {4'b0000, addr[6:3]};
      end else begin
        route.sfr_sel = 1'b1;
        route.idx     = {addr[7:3], 3'b000};
      end
    end else if (reg_en) begin
      route.idx = {3'b000, bank, addr[2:0]};
    end else if (addr[7] && !indirect) begin
      route.sfr_sel = 1'b1;
    end
  end
endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/idm_sfr.sv
module idm_sfr
  import idm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] acc,
  output logic [1:0]        bank
);
  logic [DATA_W-1:0] b_q, psw_q, dpl_q, dph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      b_q   <= '0;
      psw_q <= '0;
      dpl_q <= '0;
      dph_q <= '0;
    end else if (we) begin
      case (addr)
        SFR_ACC: acc   <= wdata;
        SFR_B:   b_q   <= wdata;
        SFR_PSW: psw_q <= wdata;
        SFR_DPL: dpl_q <= wdata;
        SFR_DPH: dph_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      SFR_ACC: rdata = acc;
      SFR_B:   rdata = b_q;
      SFR_PSW: rdata = psw_q;
      SFR_DPL: rdata = dpl_q;
      SFR_DPH: rdata = dph_q;
      default: rdata = '0;
    endcase
  end

  assign bank = psw_q[4:3];

  assert_acc_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!we || addr != SFR_ACC) |=> $stable(acc));

  assert_unimpl_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (addr[7:4] == 4'h9) |-> (rdata == '0));
endmodule

// File: rtl/idm_mapper.sv
module idm_mapper
  import idm_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter logic [7:0] BIT_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              bit_en,
  input  logic              reg_en,
  input  logic              indirect,
  input  logic [1:0]        bit_fn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_bit,
  output logic [DATA_W-1:0] acc_q
);
  route_t            route;
  logic [1:0]        bank;
  logic [DATA_W-1:0] ram_rdata, sfr_rdata, cur_byte, mod_byte, store_byte, mask;
  logic              ram_we, sfr_we, new_bit;

  idm_route #(.BIT_BASE(BIT_BASE)) u_route (
    .addr(addr), .indirect(indirect), .reg_en(reg_en),
    .bit_en(bit_en), .bank(bank), .route(route)
  );

  idm_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(route.idx),
    .wdata(store_byte), .rdata(ram_rdata)
  );

  idm_sfr #(.DATA_W(DATA_W)) u_sfr (
    .clk(clk), .rst(rst), .we(sfr_we), .addr(route.idx),
    .wdata(store_byte), .rdata(sfr_rdata), .acc(acc_q), .bank(bank)
  );

  assign cur_byte = route.sfr_sel ? sfr_rdata : ram_rdata;
  assign mask     = {{(DATA_W-1){1'b0}}, 1'b1} << route.bpos;

  always_comb begin
    case (bitfn_e'(bit_fn))
      BF_CLR:  new_bit = 1'b0;
      BF_SET:  new_bit = 1'b1;
      BF_CPL:  new_bit = ~cur_byte[route.bpos];
      default: new_bit = wr_data[0];
    endcase
    mod_byte = new_bit ? (cur_byte | mask) : (cur_byte & ~mask);
  end

  assign store_byte = bit_en ? mod_byte : wr_data;
  assign ram_we     = wr_en && !route.sfr_sel;
  assign sfr_we     = wr_en && route.sfr_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_bit   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= cur_byte;
      if (bit_en && (rd_en || wr_en)) rd_bit <= cur_byte[route.bpos];
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_valid && !rd_bit && rd_data == '0 && acc_q == '0));

  assert_read_valid_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_idle_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && $stable(rd_data)));

  assert_reg_bank_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_en && !bit_en) |-> (!route.sfr_sel && route.idx[7:5] == 3'b000 &&
                             route.idx[4:3] == bank));

  assert_bit_low_R7: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !addr[7]) |-> (!route.sfr_sel && route.idx[7:4] == BIT_BASE[7:4]));

  assert_bit_high_R8: assert property (@(posedge clk) disable iff (rst)
    (bit_en && addr[7]) |-> (route.sfr_sel && route.idx[2:0] == 3'b000));

  assert_acc_bit_set_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bit_en && addr[7:3] == 5'b11100 && bit_fn == 2'b01)
      |=> acc_q[$past(addr[2:0])]);
endmodule

// File: tb/tb_idm_mapper.sv
module tb_idm_mapper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_en = 0, wr_en = 0, bit_en = 0, reg_en = 0, indirect = 0;
  logic [1:0] bit_fn = 0;
  logic [7:0] addr = 0, wr_data = 0;
  logic [7:0] rd_data, acc_q;
  logic       rd_valid, rd_bit;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  idm_mapper dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .bit_en(bit_en),
    .reg_en(reg_en), .indirect(indirect), .bit_fn(bit_fn), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_bit(rd_bit), .acc_q(acc_q)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic op(input logic r, input logic w, input logic b, input logic rg,
                    input logic ind, input logic [1:0] fn, input logic [7:0] a,
                    input logic [7:0] d);
    @(negedge clk);
    rd_en = r; wr_en = w; bit_en = b; reg_en = rg; indirect = ind;
    bit_fn = fn; addr = a; wr_data = d;
    @(negedge clk);
    rd_en = 0; wr_en = 0; bit_en = 0; reg_en = 0; indirect = 0;
  endtask

  task automatic wr(input logic ind, input logic [7:0] a, input logic [7:0] d);
    op(0, 1, 0, 0, ind, 2'b00, a, d);
  endtask
  task automatic rd(input logic ind, input logic [7:0] a);
    op(1, 0, 0, 0, ind, 2'b00, a, 8'h00);
  endtask
  task automatic bmod(input logic [7:0] a, input logic [1:0] fn, input logic d0);
    op(0, 1, 1, 0, 0, fn, a, {7'b0, d0});
  endtask

  task automatic t_reset;
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    check("R1 rd_bit", {7'b0, rd_bit}, 8'h00);
    check("R1 acc_q", acc_q, 8'h00);
    rd(0, 8'hD0);
    check("R1 status word", rd_data, 8'h00);
    op(0, 1, 0, 1, 0, 2'b00, 8'h00, 8'h6E);
    rd(0, 8'h00);
    check("R1 bank 0 R0", rd_data, 8'h6E);
  endtask

  task automatic t_shared_low;
    wr(0, 8'h35, 8'hA5);
    rd(1, 8'h35);
    check("R2 direct->indirect", rd_data, 8'hA5);
    wr(1, 8'h12, 8'h3C);
    rd(0, 8'h12);
    check("R2 indirect->direct", rd_data, 8'h3C);
  endtask

  task automatic t_upper;
    wr(1, 8'hE0, 8'h77);
    check("R3 acc untouched", acc_q, 8'h00);
    rd(0, 8'hE0);
    check("R3 direct E0 is acc", rd_data, 8'h00);
    rd(1, 8'hE0);
    check("R3 upper RAM", rd_data, 8'h77);
  endtask

  task automatic t_sfr;
    wr(0, 8'hE0, 8'h5A);
    check("R4 acc_q", acc_q, 8'h5A);
    rd(1, 8'hE0);
    check("R4 upper RAM kept", rd_data, 8'h77);
    wr(0, 8'hF0, 8'hC3);
    wr(0, 8'h82, 8'h12);
    wr(0, 8'h83, 8'h34);
    rd(0, 8'hF0); check("R4 B", rd_data, 8'hC3);
    rd(0, 8'h82); check("R4 DPL", rd_data, 8'h12);
    rd(0, 8'h83); check("R4 DPH", rd_data, 8'h34);
  endtask

  task automatic t_unimpl;
    wr(0, 8'h90, 8'hFF);
    rd(0, 8'h90);
    check("R5 unimplemented 90h", rd_data, 8'h00);
    rd(0, 8'h80);
    check("R5 unimplemented 80h", rd_data, 8'h00);
    check("R5 acc unchanged", acc_q, 8'h5A);
  endtask

  task automatic t_banks;
    wr(0, 8'hD0, 8'h18);
    op(0, 1, 0, 1, 0, 2'b00, 8'h05, 8'h99);
    rd(0, 8'h1D);
    check("R6 bank3 R5", rd_data, 8'h99);
    wr(0, 8'hD0, 8'h08);
    op(0, 1, 0, 1, 0, 2'b00, 8'h00, 8'h11);
    rd(0, 8'h08);
    check("R6 bank1 R0", rd_data, 8'h11);
    op(1, 0, 0, 1, 0, 2'b00, 8'h00, 8'h00);
    check("R6 bank1 read R0", rd_data, 8'h11);
    wr(0, 8'hD0, 8'h00);
  endtask

  task automatic t_bit_low;
    wr(0, 8'h20, 8'h00);
    wr(0, 8'h2F, 8'h00);
    bmod(8'h00, 2'b01, 0);
    rd(0, 8'h20);
    check("R7 bit 00h -> 20h.0", rd_data, 8'h01);
    bmod(8'h7F, 2'b01, 0);
    rd(0, 8'h2F);
    check("R7 bit 7Fh -> 2Fh.7", rd_data, 8'h80);
    op(1, 0, 1, 0, 0, 2'b00, 8'h7F, 8'h00);
    check("R7 bit read 7Fh", {7'b0, rd_bit}, 8'h01);
  endtask

  task automatic t_bit_sfr;
    bmod(8'hE5, 2'b01, 0);
    check("R8 acc bit5 set", acc_q, 8'h7A);
    check("R10 old bit", {7'b0, rd_bit}, 8'h00);
    bmod(8'hE1, 2'b10, 0);
    check("R8 acc bit1 cpl", acc_q, 8'h78);
    bmod(8'hF2, 2'b01, 0);
    rd(0, 8'hF0);
    check("R8 B bit2", rd_data, 8'hC7);
    bmod(8'h85, 2'b01, 0);
    rd(0, 8'h80);
    check("R8 unimplemented bit", rd_data, 8'h00);
    bmod(8'hD3, 2'b01, 0);
    op(0, 1, 0, 1, 0, 2'b00, 8'h02, 8'h44);
    rd(0, 8'h0A);
    check("R8 status bit selects bank1", rd_data, 8'h44);
    bmod(8'hD3, 2'b00, 0);
    rd(0, 8'hD0);
    check("R8 status bit cleared", rd_data, 8'h00);
  endtask

  task automatic t_bit_fns;
    wr(0, 8'h2A, 8'h5A);
    bmod(8'h50, 2'b10, 0);
    rd(0, 8'h2A);
    check("R9 complement", rd_data, 8'h5B);
    bmod(8'h51, 2'b00, 0);
    rd(0, 8'h2A);
    check("R9 clear", rd_data, 8'h59);
    bmod(8'h57, 2'b11, 1);
    rd(0, 8'h2A);
    check("R9 load one", rd_data, 8'hD9);
    bmod(8'h54, 2'b11, 0);
    rd(0, 8'h2A);
    check("R9 load zero", rd_data, 8'hC9);
  endtask

  task automatic t_timing;
    bmod(8'h50, 2'b10, 0);
    check("R10 rd_bit pre-change", {7'b0, rd_bit}, 8'h01);
    check("R10 no valid on write", {7'b0, rd_valid}, 8'h00);
    check("R10 rd_data held", rd_data, 8'hC9);
    rd(0, 8'h2A);
    check("R10 valid on read", {7'b0, rd_valid}, 8'h01);
    check("R10 data after cpl", rd_data, 8'hC8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_shared_low;
    t_upper;
    t_sfr;
    t_unimpl;
    t_banks;
    t_bit_low;
    t_bit_sfr;
    t_bit_fns;
    t_timing;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule